// File: doc/BRIEF.md
# Register-to-Register Integer ALU

This block is the combinational arithmetic and logic unit behind the register-to-register integer instructions of a 32-bit core. It receives two operand words together with the two function fields of the instruction word: the 7-bit upper function field and the 3-bit lower function field. In the same cycle it returns the result word and a flag that marks an operation it does not support. There is no clock and no state. The result depends only on the present inputs.

Nine operations are decoded. They are add, subtract, left shift, right shift with zero fill, signed and unsigned less-than, and the bitwise xor, or and and. Only the low five bits of the second operand set the shift distance. The arithmetic right shift encoding is reported as unsupported. So is every other function-field pair. In those cases the result is forced to zero and the upstream pipeline can raise its own exception. Sums and differences wrap and give no overflow indication.

Top module: `rtype_alu`

## Requirements
- R1: With upper field 0000000 and lower field 000, the result is op_a + op_b modulo 2^32, with no overflow indication.
- R2: With upper field 0100000 and lower field 000, the result is op_a - op_b modulo 2^32.
- R3: With upper field 0000000 and lower field 001, the result is op_a shifted left by op_b[4:0]. Vacated low bits are zero and op_b[31:5] has no effect.
- R4: With upper field 0000000 and lower field 010, the result is 1 when op_a < op_b as two's-complement values and 0 otherwise. Bits 31..1 are always zero.
- R5: With upper field 0000000 and lower field 011, the result is 1 when op_a < op_b as unsigned values and 0 otherwise.
- R6: With upper field 0000000, lower field 100 gives op_a XOR op_b, 110 gives OR and 111 gives AND.
- R7: With upper field 0000000 and lower field 101, the result is op_a shifted right by op_b[4:0]. Vacated high bits are zero and op_b[31:5] has no effect.
- R8: The pair upper field 0100000 with lower field 101 (sign-filling right shift) drives illegal to 1 and result to zero.
- R9: Every function-field pair outside the nine listed above drives illegal to 1 and result to zero. The nine listed pairs drive illegal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (value to shift for shifts) |
| op_b | input | 32 | Second operand (low 5 bits give shift distance for shifts) |
| funct7 | input | 7 | Upper function field of the instruction word |
| funct3 | input | 3 | Lower function field of the instruction word |
| result | output | 32 | Operation result, zero when illegal |
| illegal | output | 1 | High when the function-field pair is not supported |

## Verification
The checker evaluates its immediate assertions combinationally. It assumes that every input carries a known 0/1 value whenever the function fields name an operation, because an unknown operand would make the algebraic checks meaningless. The assertions also assume that the inputs stay constant while the unit settles. The stimulus meets both assumptions. It always drives fully defined words, changes them only just after a rising edge of the bench clock and reads the outputs at the falling edge. It covers both decoded and undecoded function-field pairs, so the illegal-path assertions are exercised as well as the arithmetic ones.

// File: rtl/rtype_alu_pkg.sv
package rtype_alu_pkg;

  localparam int unsigned F7W = 7;
  localparam int unsigned F3W = 3;

  localparam logic [F7W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7W-1:0] F7_ALT  = 7'b0100000;

  localparam logic [F3W-1:0] F3_ADDSUB = 3'b000;
  localparam logic [F3W-1:0] F3_SLL    = 3'b001;
  localparam logic [F3W-1:0] F3_SLT    = 3'b010;
  localparam logic [F3W-1:0] F3_SLTU   = 3'b011;
  localparam logic [F3W-1:0] F3_XOR    = 3'b100;
  localparam logic [F3W-1:0] F3_SHR    = 3'b101;
  localparam logic [F3W-1:0] F3_OR     = 3'b110;
  localparam logic [F3W-1:0] F3_AND    = 3'b111;

  typedef enum logic [3:0] {
    OP_ADD,
    OP_SUB,
    OP_SLL,
    OP_SLT,
    OP_SLTU,
    OP_XOR,
    OP_SRL,
    OP_OR,
    OP_AND,
    OP_NONE
  } alu_op_e;

endpackage

// File: rtl/rtype_alu_decode.sv
module rtype_alu_decode
  import rtype_alu_pkg::*;
(
  input  logic [F7W-1:0] funct7,
  input  logic [F3W-1:0] funct3,
  output alu_op_e        op,
  output logic           op_bad
);

  always_comb begin
    op = OP_NONE;
    if (funct7 == F7_BASE) begin
      case (funct3)
        F3_ADDSUB: op = OP_ADD;
        F3_SLL:    op = OP_SLL;
        F3_SLT:    op = OP_SLT;
        F3_SLTU:   op = OP_SLTU;
        F3_XOR:    op = OP_XOR;
        F3_SHR:    op = OP_SRL;
        F3_OR:     op = OP_OR;
        F3_AND:    op = OP_AND;
        default:   op = OP_NONE;
      endcase
    end else if (funct7 == F7_ALT) begin
      // only subtraction is decoded here; the sign-filling shift stays unsupported
      if (funct3 == F3_ADDSUB) begin
        op = OP_SUB;
      end
    end
  end

  assign op_bad = (op == OP_NONE);

endmodule

// File: rtl/rtype_alu_addsub.sv
module rtype_alu_addsub #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            subtract,
  output logic [XLEN-1:0] sum,
  output logic            lt_signed,
  output logic            lt_unsigned
);

  localparam int unsigned MSB = XLEN - 1;

  logic [XLEN-1:0] b_eff;
  logic [XLEN:0]   wide;
  logic            carry;

  assign b_eff = b ^ {XLEN{subtract}};
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, subtract};
  assign sum   = wide[XLEN-1:0];
  assign carry = wide[XLEN];

  // valid only while subtract is high: a borrow means a < b unsigned
  assign lt_unsigned = ~carry;
  assign lt_signed   = (a[MSB] != b[MSB]) ? a[MSB] : wide[MSB];

endmodule

// File: rtl/rtype_alu_shift.sv
module rtype_alu_shift #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data,
  input  logic [SHW-1:0]  shamt,
  input  logic            to_right,
  output logic [XLEN-1:0] shifted
);

  logic [XLEN-1:0] data_rev;
  logic [XLEN-1:0] core_in;
  logic [XLEN-1:0] core_out;
  logic [XLEN-1:0] out_rev;
  logic [XLEN-1:0] stage [0:SHW];

  genvar i;
  generate
    for (i = 0; i < XLEN; i++) begin : g_rev
      assign data_rev[i] = data[XLEN-1-i];
      assign out_rev[i]  = core_out[XLEN-1-i];
    end
  endgenerate

  // a right shift is a left shift of the bit-reversed word
  assign core_in  = to_right ? data_rev : data;
  assign stage[0] = core_in;

  genvar k;
  generate
    for (k = 0; k < SHW; k++) begin : g_stage
      assign stage[k+1] = shamt[k] ? (stage[k] << (2 ** k)) : stage[k];
    end
  endgenerate

  assign core_out = stage[SHW];
  assign shifted  = to_right ? out_rev : core_out;

endmodule

// File: rtl/rtype_alu.sv
module rtype_alu
  import rtype_alu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [F7W-1:0]  funct7,
  input  logic [F3W-1:0]  funct3,
  output logic [XLEN-1:0] result,
  output logic            illegal
);

  alu_op_e         op;
  logic            op_bad;
  logic            do_sub;
  logic            do_right;
  logic [XLEN-1:0] arith;
  logic            lt_s;
  logic            lt_u;
  logic [XLEN-1:0] shifted;

  rtype_alu_decode u_dec (
    .funct7 (funct7),
    .funct3 (funct3),
    .op     (op),
    .op_bad (op_bad)
  );

  assign do_sub   = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
  assign do_right = (op == OP_SRL);

  rtype_alu_addsub #(.XLEN(XLEN)) u_add (
    .a           (op_a),
    .b           (op_b),
    .subtract    (do_sub),
    .sum         (arith),
    .lt_signed   (lt_s),
    .lt_unsigned (lt_u)
  );

  rtype_alu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shf (
    .data     (op_a),
    .shamt    (op_b[SHW-1:0]),
    .to_right (do_right),
    .shifted  (shifted)
  );

  always_comb begin
    result = '0;
    case (op)
      OP_ADD,
      OP_SUB:  result = arith;
      OP_SLL,
      OP_SRL:  result = shifted;
      OP_SLT:  result = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU: result = {{(XLEN-1){1'b0}}, lt_u};
      OP_XOR:  result = op_a ^ op_b;
      OP_OR:   result = op_a | op_b;
      OP_AND:  result = op_a & op_b;
      default: result = '0;
    endcase
  end

  assign illegal = op_bad;

endmodule

// File: rtl/rtype_alu_chk.sv
module rtype_alu_chk
  import rtype_alu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b,
  input logic [F7W-1:0]  funct7,
  input logic [F3W-1:0]  funct3,
  input logic [XLEN-1:0] result,
  input logic            illegal
);

  logic base_f7;
  assign base_f7 = (funct7 == F7_BASE);

  always_comb begin
    if (illegal) begin
      assert_illegal_zero_R9: assert (result == '0)
        else $error("illegal op produced nonzero result");
    end
    if (funct7 == F7_ALT && funct3 == F3_SHR) begin
      assert_sra_flagged_R8: assert (illegal)
        else $error("sign-filling shift not flagged");
    end
    if (base_f7 && funct3 == F3_ADDSUB) begin
      assert_add_inverse_R1: assert ((result - op_b) == op_a && !illegal)
        else $error("add result inconsistent");
    end
    if (funct7 == F7_ALT && funct3 == F3_ADDSUB) begin
      assert_sub_inverse_R2: assert ((result + op_b) == op_a && !illegal)
        else $error("sub result inconsistent");
    end
    if (base_f7 && funct3 == F3_SLL && op_b[SHW-1:0] != '0) begin
      assert_sll_lsb_zero_R3: assert (result[0] == 1'b0)
        else $error("left shift left a low bit set");
    end
    if (base_f7 && funct3 == F3_SLT) begin
      assert_slt_narrow_R4: assert (result[XLEN-1:1] == '0)
        else $error("signed compare has upper bits set");
    end
    if (base_f7 && funct3 == F3_SLTU) begin
      assert_sltu_strict_R5: assert (result[XLEN-1:1] == '0 && !(result[0] && op_a == op_b))
        else $error("unsigned compare malformed");
    end
    if (base_f7 && funct3 == F3_XOR) begin
      assert_xor_inverse_R6: assert ((result ^ op_b) == op_a)
        else $error("xor result inconsistent");
    end
    if (base_f7 && funct3 == F3_SHR && op_b[SHW-1:0] != '0) begin
      assert_srl_msb_zero_R7: assert (result[XLEN-1] == 1'b0)
        else $error("right shift left the top bit set");
    end
  end

endmodule

bind rtype_alu rtype_alu_chk #(.XLEN(XLEN)) u_chk (
  .op_a    (op_a),
  .op_b    (op_b),
  .funct7  (funct7),
  .funct3  (funct3),
  .result  (result),
  .illegal (illegal)
);

// File: tb/sim_rtype_alu.sv
module sim_rtype_alu;

  localparam int NV    = 19;
  localparam int NRAND = 400;
  localparam int WD_LIMIT = 20000;

  typedef struct packed {
    logic [6:0]  f7;
    logic [2:0]  f3;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
    logic        ill;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{7'h00, 3'd0, 32'h0000_0007, 32'h0000_0005, 32'h0000_000C, 1'b0}, // R1
    '{7'h00, 3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b0}, // R1 wrap
    '{7'h20, 3'd0, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE, 1'b0}, // R2
    '{7'h20, 3'd0, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0}, // R2 wrap
    '{7'h00, 3'd1, 32'h0000_0001, 32'h0000_001F, 32'h8000_0000, 1'b0}, // R3
    '{7'h00, 3'd1, 32'h0000_0003, 32'h0000_0021, 32'h0000_0006, 1'b0}, // R3 high count bits ignored
    '{7'h00, 3'd2, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0}, // R4
    '{7'h00, 3'd3, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b0}, // R5
    '{7'h00, 3'd2, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0}, // R4
    '{7'h00, 3'd3, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0}, // R5
    '{7'h00, 3'd2, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0}, // R4 extremes
    '{7'h00, 3'd2, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b0}, // R4 equal
    '{7'h00, 3'd4, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0FF0_0FF0, 1'b0}, // R6 xor
    '{7'h00, 3'd5, 32'h8000_0000, 32'h0000_001F, 32'h0000_0001, 1'b0}, // R7
    '{7'h00, 3'd5, 32'hF000_0000, 32'hFFFF_FFE4, 32'h0F00_0000, 1'b0}, // R7 zero fill, high bits ignored
    '{7'h00, 3'd6, 32'h0F0F_0000, 32'h0000_00F0, 32'h0F0F_00F0, 1'b0}, // R6 or
    '{7'h00, 3'd7, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'h00F0_00F0, 1'b0}, // R6 and
    '{7'h20, 3'd5, 32'h8000_0000, 32'h0000_0001, 32'h0000_0000, 1'b1}, // R8
    '{7'h01, 3'd0, 32'h1234_5678, 32'h1111_1111, 32'h0000_0000, 1'b1}  // R9
  };

  logic        clk;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic [6:0]  funct7;
  logic [2:0]  funct3;
  logic [31:0] result;
  logic        illegal;

  int checks;
  int errors;

  rtype_alu u0 (
    .op_a    (op_a),
    .op_b    (op_b),
    .funct7  (funct7),
    .funct3  (funct3),
    .result  (result),
    .illegal (illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic string req_of(input logic [6:0] f7, input logic [2:0] f3);
    if (f7 == 7'h00) begin
      case (f3)
        3'd0: return "R1";
        3'd1: return "R3";
        3'd2: return "R4";
        3'd3: return "R5";
        3'd5: return "R7";
        default: return "R6";
      endcase
    end
    if (f7 == 7'h20 && f3 == 3'd0) return "R2";
    if (f7 == 7'h20 && f3 == 3'd5) return "R8";
    return "R9";
  endfunction

  task automatic model(input logic [6:0] f7, input logic [2:0] f3,
                       input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic ill);
    r   = 32'h0;
    ill = 1'b0;
    if (f7 == 7'h00) begin
      case (f3)
        3'd0: r = a + b;
        3'd1: r = a << b[4:0];
        3'd2: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        3'd3: r = (a < b) ? 32'd1 : 32'd0;
        3'd4: r = a ^ b;
        3'd5: r = a >> b[4:0];
        3'd6: r = a | b;
        default: r = a & b;
      endcase
    end else if (f7 == 7'h20 && f3 == 3'd0) begin
      r = a - b;
    end else begin
      ill = 1'b1;
    end
  endtask

  task automatic apply_check(input logic [6:0] f7, input logic [2:0] f3,
                             input logic [31:0] a, input logic [31:0] b,
                             input logic [31:0] exp, input logic exp_ill,
                             input string tag);
    @(posedge clk);
    funct7 <= f7;
    funct3 <= f3;
    op_a   <= a;
    op_b   <= b;
    @(negedge clk);
    checks++;
    if (result !== exp || illegal !== exp_ill) begin
      errors++;
      $display("FAIL %s %s f7=%h f3=%0d a=%h b=%h: result=%h illegal=%b expected result=%h illegal=%b",
               req_of(f7, f3), tag, f7, f3, a, b, result, illegal, exp, exp_ill);
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors + 1);
    $finish;
  end

  initial begin
    logic [31:0] er;
    logic        ei;
    checks = 0;
    errors = 0;
    op_a   = '0;
    op_b   = '0;
    funct7 = '0;
    funct3 = '0;
    repeat (3) @(posedge clk);

    // idle inputs: zero operands decode as add, R1 gives zero and no flag
    apply_check(7'h00, 3'd0, 32'h0, 32'h0, 32'h0, 1'b0, "idle");

    for (int i = 0; i < NV; i++) begin
      apply_check(VEC[i].f7, VEC[i].f3, VEC[i].a, VEC[i].b, VEC[i].exp, VEC[i].ill, "table");
    end

    // R9: every undecoded lower field under the alternate upper field
    for (int f = 1; f < 8; f++) begin
      if (f != 5) apply_check(7'h20, 3'(f), 32'hDEAD_BEEF, 32'h0000_0003, 32'h0, 1'b1, "alt-field");
    end
    // R9: single stray bits in the upper field
    for (int s = 0; s < 7; s++) begin
      if (s != 5) apply_check(7'(1 << s), 3'd4, 32'hFFFF_FFFF, 32'h1234_0000, 32'h0, 1'b1, "stray-bit");
    end

    // R3 and R7: every shift distance with junk in the upper count bits
    for (int sh = 0; sh < 32; sh++) begin
      logic [31:0] bb;
      bb = {27'h5A5A5A5, 5'(sh)};
      model(7'h00, 3'd1, 32'h8765_4321, bb, er, ei);
      apply_check(7'h00, 3'd1, 32'h8765_4321, bb, er, ei, "sll sweep");
      model(7'h00, 3'd5, 32'h8765_4321, bb, er, ei);
      apply_check(7'h00, 3'd5, 32'h8765_4321, bb, er, ei, "srl sweep");
    end

    // random operands over decoded and undecoded field pairs
    for (int n = 0; n < NRAND; n++) begin
      logic [6:0]  f7;
      logic [2:0]  f3;
      logic [31:0] a;
      logic [31:0] b;
      int          pick;
      pick = int'($urandom_range(0, 9));
      f7 = (pick < 6) ? 7'h00 : (pick < 9) ? 7'h20 : 7'($urandom);
      f3 = 3'($urandom);
      a  = $urandom;
      b  = (pick == 3) ? a : $urandom;
      model(f7, f3, a, b, er, ei);
      apply_check(f7, f3, a, b, er, ei, "random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule